// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block turns 32-bit PCI DMA addresses into system physical addresses. Several target windows are configured from outside the block. Each window has an enable bit, a mode bit, a base field, a mask field and a translated-base value. An incoming address that falls inside a window is mapped in one of two ways, chosen by that window's mode bit:

- **Direct mode** rewrites the address by concatenation.
- **Scatter-gather mode** looks the address up in a map of 8KB pages. Recently used map entries are held in a small fully associative translation cache.

A miss in the cache issues a fetch of one map entry. The fetch uses a simple request/fill handshake toward memory. The DMA response is held back until the fill returns. A requester may ask for the loaded entry to be locked. A locked entry is never replaced and is never dropped by a cache flush.

The block accepts one request at a time. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high. A response is a single-cycle `rsp_valid` pulse.

Top module: `dma_win_xlate`

## Requirements
- R1: Window `w` matches when its enable bit is set and `((addr[31:20] ^ base_w) & ~mask_w) == 0`. A set mask bit widens the window by letting that address bit through. When several windows match, the lowest-numbered one is used.
- R2: When no enabled window matches, the response comes in the cycle after acceptance with `rsp_hit=0`, `rsp_err=0` and `rsp_pa=0`.
- R3: In direct mode, physical bit `b` equals `addr[b]` when `b<20`, or when `b<32` and mask bit `b-20` is set. Otherwise it equals bit `b` of the window's translated base. The response comes in the cycle after acceptance with `rsp_hit=1`.
- R4: On a scatter-gather miss, the page index is the in-window address bits 31..13 (offset bits only), packed down from bit 13. The map-entry address is `translated_base + index*8`. From the cycle after acceptance, `fetch_valid` stays high with a stable `fetch_addr`, `req_ready` stays low, and no response is given until `fill_valid` arrives.
- R5: A map entry on `fill_data` carries a valid flag in bit 0 and a physical page number in bits 21..1. The response comes in the cycle after the fill, with `rsp_pa = {ppn, addr[12:0]}`.
- R6: A fill whose bit 0 is 0 gives `rsp_hit=1`, `rsp_err=1` and `rsp_pa=0`. Nothing is loaded into the cache, so the next access to that page fetches again.
- R7: A scatter-gather access whose page tag (`addr[31:13]`) is held in the cache responds in the cycle after acceptance, from the cached page number, with no fetch.
- R8: The cache has 8 entries. A fill takes the first unlocked entry at or after a rotating pointer, and the pointer then moves one past that entry.
- R9: A fill requested with `req_lock=1` locks its entry. A locked entry is never replaced and never cleared by a flush.
- R10: When every entry is locked, a valid fill still produces the correct response, but the cache is left unchanged.
- R11: A one-cycle `inv_all` pulse drops every unlocked entry, so that an access accepted on the next cycle misses.
- R12: After reset, `req_ready=1`, `rsp_valid=0`, `fetch_valid=0` and the cache holds no entries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | NWIN | Per-window enable |
| cfg_sg | input | NWIN | Per-window mode: 1 selects scatter-gather, 0 selects direct |
| cfg_base | input | NWIN*12 | Per-window compare base for address bits 31..20 |
| cfg_mask | input | NWIN*12 | Per-window mask; a set bit excludes that bit from the compare |
| cfg_tbase | input | NWIN*PA_W | Per-window translated base (direct) or map base (scatter-gather) |
| req_valid | input | 1 | DMA address request |
| req_addr | input | 32 | PCI DMA address |
| req_lock | input | 1 | Lock the cache entry loaded by this request |
| req_ready | output | 1 | Block can accept a request |
| rsp_valid | output | 1 | One-cycle response strobe |
| rsp_hit | output | 1 | A window matched |
| rsp_err | output | 1 | The map entry was invalid |
| rsp_pa | output | PA_W | Physical address |
| fetch_valid | output | 1 | Map-entry fetch pending |
| fetch_addr | output | PA_W | Physical address of the map entry |
| fill_valid | input | 1 | Map entry returned |
| fill_data | input | PA_W-12 | Returned map entry: page number and valid flag |
| inv_all | input | 1 | Flush all unlocked cache entries |

## Verification
The bench builds the block with its defaults: four windows, an 8-entry cache and a 34-bit physical address. With these values, nine distinct pages are enough to wrap the replacement pointer. Eight locked loads are enough to fill the cache completely and reach the uncached path. Two of the four windows overlap, which exercises priority. A disabled window tests the enable bit. A 4MB scatter-gather window keeps random pages in a small set, so hits and misses both occur often.

// File: rtl/dma_win_pkg.sv
package dma_win_pkg;
  localparam int ADDR_W = 32;
  localparam int PG_W   = 13;

  typedef enum logic {XL_IDLE, XL_WAIT} xl_state_e;
endpackage

// File: rtl/dma_win_match.sv
module dma_win_match #(
  parameter int NWIN = 4,
  parameter int CW   = 12,
  localparam int SW  = $clog2(NWIN)
) (
  input  logic [NWIN-1:0]    en,
  input  logic [NWIN*CW-1:0] base,
  input  logic [NWIN*CW-1:0] mask,
  input  logic [CW-1:0]      addr_hi,
  output logic               any,
  output logic [SW-1:0]      sel
);
  logic [NWIN-1:0] hits;

  // one comparator per window
  for (genvar g = 0; g < NWIN; g++) begin : g_cmp
    assign hits[g] = en[g] &&
      (((addr_hi ^ base[g*CW +: CW]) & ~mask[g*CW +: CW]) == '0);
  end

  // lowest index wins
  always_comb begin
    any = 1'b0;
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) begin
      if (hits[i]) begin
        any = 1'b1;
        sel = SW'(i);
      end
    end
  end
endmodule

// File: rtl/dma_win_tlb.sv
module dma_win_tlb #(
  parameter int N     = 8,
  parameter int TAG_W = 19,
  parameter int PPN_W = 21,
  localparam int IW   = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TAG_W-1:0] lk_tag,
  output logic             lk_hit,
  output logic [PPN_W-1:0] lk_ppn,
  input  logic             inv_all,
  input  logic             wr_en,
  input  logic [TAG_W-1:0] wr_tag,
  input  logic [PPN_W-1:0] wr_ppn,
  input  logic             wr_lock,
  output logic             vic_ok,
  output logic [IW-1:0]    vic_idx,
  output logic [N-1:0]     ent_valid,
  output logic [N-1:0]     ent_lock
);
  logic [TAG_W-1:0] tag_q [N];
  logic [PPN_W-1:0] ppn_q [N];
  logic [N-1:0]     hit_vec;
  logic [IW-1:0]    ptr;

  for (genvar g = 0; g < N; g++) begin : g_cam
    assign hit_vec[g] = ent_valid[g] && (tag_q[g] == lk_tag);
  end

  always_comb begin
    lk_hit = |hit_vec;
    lk_ppn = '0;
    for (int i = 0; i < N; i++) begin
      if (hit_vec[i]) lk_ppn = ppn_q[i];
    end
  end

  // rotating search for the first unlocked slot
  always_comb begin
    vic_ok  = 1'b0;
    vic_idx = '0;
    for (int k = 0; k < N; k++) begin
      int j;
      j = int'(ptr) + k;
      if (j >= N) j = j - N;
      if (!vic_ok && !ent_lock[j]) begin
        vic_ok  = 1'b1;
        vic_idx = IW'(j);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid <= '0;
      ent_lock  <= '0;
      ptr       <= '0;
    end else begin
      if (inv_all) ent_valid <= ent_valid & ent_lock;
      if (wr_en) begin
        ent_valid[vic_idx] <= 1'b1;
        ent_lock[vic_idx]  <= wr_lock;
        ptr <= (int'(vic_idx) == N - 1) ? '0 : vic_idx + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      tag_q[vic_idx] <= wr_tag;
      ppn_q[vic_idx] <= wr_ppn;
    end
  end
endmodule

// File: rtl/dma_win_xlate.sv
module dma_win_xlate
  import dma_win_pkg::*;
#(
  parameter int NWIN   = 4,
  parameter int TLB_N  = 8,
  parameter int PA_W   = 34,
  parameter int CMP_LO = 20,
  localparam int CW    = ADDR_W - CMP_LO,
  localparam int TAG_W = ADDR_W - PG_W,
  localparam int PPN_W = PA_W - PG_W,
  localparam int SW    = $clog2(NWIN),
  localparam int TIW   = $clog2(TLB_N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NWIN-1:0]      cfg_en,
  input  logic [NWIN-1:0]      cfg_sg,
  input  logic [NWIN*CW-1:0]   cfg_base,
  input  logic [NWIN*CW-1:0]   cfg_mask,
  input  logic [NWIN*PA_W-1:0] cfg_tbase,
  input  logic                 req_valid,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic                 req_lock,
  output logic                 req_ready,
  output logic                 rsp_valid,
  output logic                 rsp_hit,
  output logic                 rsp_err,
  output logic [PA_W-1:0]      rsp_pa,
  output logic                 fetch_valid,
  output logic [PA_W-1:0]      fetch_addr,
  input  logic                 fill_valid,
  input  logic [PPN_W:0]       fill_data,
  input  logic                 inv_all
);
  // ---------------- arithmetic helpers ----------------
  function automatic logic [ADDR_W-1:0] offset_mask(input logic [CW-1:0] m);
    return {m, {CMP_LO{1'b1}}};
  endfunction

  function automatic logic [PA_W-1:0] direct_xlate(input logic [ADDR_W-1:0] a,
      input logic [ADDR_W-1:0] om, input logic [PA_W-1:0] tb);
    return (tb & ~PA_W'(om)) | PA_W'(a & om);
  endfunction

  function automatic logic [TAG_W-1:0] sg_index(input logic [ADDR_W-1:0] a,
      input logic [ADDR_W-1:0] om);
    return TAG_W'((a & om) >> PG_W);
  endfunction

  function automatic logic [PA_W-1:0] map_addr(input logic [PA_W-1:0] tb,
      input logic [TAG_W-1:0] idx);
    return tb + (PA_W'(idx) << 3);
  endfunction

  function automatic logic [PA_W-1:0] sg_xlate(input logic [PPN_W-1:0] ppn,
      input logic [ADDR_W-1:0] a);
    return {ppn, a[PG_W-1:0]};
  endfunction

  // ---------------- window select ----------------
  logic            win_any;
  logic [SW-1:0]   win_sel;
  logic            sel_sg;
  logic [CW-1:0]   sel_mask;
  logic [PA_W-1:0] sel_tbase;

  dma_win_match #(.NWIN(NWIN), .CW(CW)) u_match (
    .en(cfg_en), .base(cfg_base), .mask(cfg_mask),
    .addr_hi(req_addr[ADDR_W-1:CMP_LO]), .any(win_any), .sel(win_sel)
  );

  always_comb begin
    sel_sg    = cfg_sg[win_sel];
    sel_mask  = cfg_mask[int'(win_sel)*CW +: CW];
    sel_tbase = cfg_tbase[int'(win_sel)*PA_W +: PA_W];
  end

  logic [ADDR_W-1:0] omask;
  logic [PA_W-1:0]   dir_pa;
  logic [PA_W-1:0]   map_pa;
  assign omask  = offset_mask(sel_mask);
  assign dir_pa = direct_xlate(req_addr, omask, sel_tbase);
  assign map_pa = map_addr(sel_tbase, sg_index(req_addr, omask));

  // ---------------- control state ----------------
  xl_state_e         st;
  logic [ADDR_W-1:0] hold_addr;
  logic              hold_lock;
  logic [PA_W-1:0]   hold_map;

  // named events for the checker
  logic             accept, go_miss, fill_take, fill_vbit, fill_write;
  logic             lk_hit, vic_ok;
  logic [PPN_W-1:0] lk_ppn, fill_ppn;
  logic [TIW-1:0]   vic_idx;
  logic [TLB_N-1:0] ent_valid, ent_lock;

  assign req_ready   = (st == XL_IDLE);
  assign fetch_valid = (st == XL_WAIT);
  assign fetch_addr  = hold_map;
  assign accept      = req_valid && req_ready;
  assign go_miss     = accept && win_any && sel_sg && !lk_hit;
  assign fill_take   = fetch_valid && fill_valid;
  assign fill_vbit   = fill_data[0];
  assign fill_ppn    = fill_data[PPN_W:1];
  assign fill_write  = fill_take && fill_vbit && vic_ok;

  dma_win_tlb #(.N(TLB_N), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_tlb (
    .clk(clk), .rst_n(rst_n),
    .lk_tag(req_addr[ADDR_W-1:PG_W]), .lk_hit(lk_hit), .lk_ppn(lk_ppn),
    .inv_all(inv_all),
    .wr_en(fill_write), .wr_tag(hold_addr[ADDR_W-1:PG_W]),
    .wr_ppn(fill_ppn), .wr_lock(hold_lock),
    .vic_ok(vic_ok), .vic_idx(vic_idx),
    .ent_valid(ent_valid), .ent_lock(ent_lock)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= XL_IDLE;
      hold_addr <= '0;
      hold_lock <= 1'b0;
      hold_map  <= '0;
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_pa    <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (accept) begin
        if (go_miss) begin
          st        <= XL_WAIT;
          hold_addr <= req_addr;
          hold_lock <= req_lock;
          hold_map  <= map_pa;
        end else begin
          rsp_valid <= 1'b1;
          rsp_hit   <= win_any;
          rsp_err   <= 1'b0;
          if (!win_any)    rsp_pa <= '0;
          else if (sel_sg) rsp_pa <= sg_xlate(lk_ppn, req_addr);
          else             rsp_pa <= dir_pa;
        end
      end else if (fill_take) begin
        st        <= XL_IDLE;
        rsp_valid <= 1'b1;
        rsp_hit   <= 1'b1;
        rsp_err   <= !fill_vbit;
        rsp_pa    <= fill_vbit ? sg_xlate(fill_ppn, hold_addr) : '0;
      end
    end
  end
endmodule

// File: rtl/dma_win_chk.sv
module dma_win_chk #(
  parameter int N    = 8,
  parameter int PA_W = 34,
  localparam int IW  = $clog2(N)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            accept,
  input logic            go_miss,
  input logic            rsp_valid,
  input logic            rsp_hit,
  input logic            rsp_err,
  input logic [PA_W-1:0] rsp_pa,
  input logic            fetch_valid,
  input logic [PA_W-1:0] fetch_addr,
  input logic            fill_valid,
  input logic            fill_vbit,
  input logic            fill_write,
  input logic            vic_ok,
  input logic [IW-1:0]   vic_idx,
  input logic [N-1:0]    ent_valid,
  input logic [N-1:0]    ent_lock,
  input logic            inv_all
);
  // R2
  nohit_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_hit |-> !rsp_err && rsp_pa == '0)
    else $error("nohit_clean_chk");

  // R7
  quick_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept && !go_miss |=> rsp_valid && !fetch_valid)
    else $error("quick_rsp_chk");

  // R4
  miss_fetch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    go_miss |=> fetch_valid && !req_ready && !rsp_valid)
    else $error("miss_fetch_chk");

  // R4
  fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fill_valid |=> fetch_valid && $stable(fetch_addr) && !rsp_valid)
    else $error("fetch_hold_chk");

  // R5
  fill_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fill_valid |=> rsp_valid && !fetch_valid)
    else $error("fill_rsp_chk");

  // R6
  bad_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fill_valid && !fill_vbit |-> !fill_write)
    else $error("bad_entry_chk");

  // R6
  bad_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fill_valid && !fill_vbit |=> rsp_err)
    else $error("bad_err_chk");

  // R9
  victim_unlocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_write |-> !ent_lock[vic_idx])
    else $error("victim_unlocked_chk");

  // R9
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (ent_lock & $past(ent_lock)) == $past(ent_lock))
    else $error("lock_sticky_chk");

  // R10
  full_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && fill_valid && fill_vbit && !vic_ok && !inv_all |=> $stable(ent_valid))
    else $error("full_lock_chk");

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inv_all && !fill_write |=> (ent_valid & ~ent_lock) == '0)
    else $error("flush_chk");
endmodule

bind dma_win_xlate dma_win_chk #(.N(TLB_N), .PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .accept(accept),
  .go_miss(go_miss), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
  .rsp_err(rsp_err), .rsp_pa(rsp_pa), .fetch_valid(fetch_valid),
  .fetch_addr(fetch_addr), .fill_valid(fill_valid), .fill_vbit(fill_vbit),
  .fill_write(fill_write), .vic_ok(vic_ok), .vic_idx(vic_idx),
  .ent_valid(ent_valid), .ent_lock(ent_lock), .inv_all(inv_all)
);

// File: tb/sim_dma_win_xlate.sv
module sim_dma_win_xlate;
  localparam int CLK_PERIOD = 10;
  localparam int NW = 4;
  localparam int PA = 34;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NW-1:0] cfg_en, cfg_sg;
  logic [NW*12-1:0] cfg_base, cfg_mask;
  logic [NW*PA-1:0] cfg_tbase;
  logic req_valid = 1'b0, req_lock = 1'b0, req_ready;
  logic [31:0] req_addr = '0;
  logic rsp_valid, rsp_hit, rsp_err;
  logic [PA-1:0] rsp_pa, fetch_addr;
  logic fetch_valid;
  logic fill_valid = 1'b0;
  logic [21:0] fill_data = '0;
  logic inv_all = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dma_win_xlate u0 (
    .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_sg(cfg_sg),
    .cfg_base(cfg_base), .cfg_mask(cfg_mask), .cfg_tbase(cfg_tbase),
    .req_valid(req_valid), .req_addr(req_addr), .req_lock(req_lock),
    .req_ready(req_ready), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
    .rsp_err(rsp_err), .rsp_pa(rsp_pa), .fetch_valid(fetch_valid),
    .fetch_addr(fetch_addr), .fill_valid(fill_valid), .fill_data(fill_data),
    .inv_all(inv_all)
  );

  // window setup
  logic          w_en   [NW] = '{1'b1, 1'b1, 1'b1, 1'b0};
  logic          w_sg   [NW] = '{1'b0, 1'b1, 1'b0, 1'b0};
  logic [11:0]   w_base [NW] = '{12'h100, 12'h200, 12'h104, 12'h400};
  logic [11:0]   w_mask [NW] = '{12'h00F, 12'h003, 12'h000, 12'h001};
  logic [PA-1:0] w_tb   [NW] = '{34'h2_0000_0000, 34'h0_8000_0000,
                                 34'h1_5550_0000, 34'h1_2340_0000};

  int nchk = 0;
  int nerr = 0;
  logic [PA-1:0] bad_map = '1;

  // reference cache state
  logic        m_v [8];
  logic        m_l [8];
  logic [18:0] m_t [8];
  logic [20:0] m_p [8];
  int          m_ptr;

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %h expected %h", r, act, exp);
    end
  endtask

  function automatic int exp_win(input logic [31:0] a);
    for (int w = 0; w < NW; w++) begin
      bit ok = w_en[w];
      for (int b = 0; b < 12; b++)
        if (!w_mask[w][b] && a[20+b] != w_base[w][b]) ok = 0;
      if (ok) return w;
    end
    return -1;
  endfunction

  function automatic logic [PA-1:0] exp_direct(input logic [31:0] a, input int w);
    logic [PA-1:0] p;
    for (int b = 0; b < PA; b++) begin
      if (b < 20 || (b < 32 && w_mask[w][b-20])) p[b] = a[b];
      else p[b] = w_tb[w][b];
    end
    return p;
  endfunction

  function automatic logic [PA-1:0] exp_map(input logic [31:0] a, input int w);
    logic [PA-1:0] idx = '0;
    for (int b = 13; b < 32; b++)
      if (b < 20 || w_mask[w][b-20]) idx[b-13] = a[b];
    return w_tb[w] + idx * 8;
  endfunction

  function automatic logic [20:0] mem_ppn(input logic [PA-1:0] fa);
    return fa[23:3] ^ 21'h15A5A;
  endfunction

  task automatic model_clear();
    for (int i = 0; i < 8; i++) begin
      m_v[i] = 0; m_l[i] = 0; m_t[i] = '0; m_p[i] = '0;
    end
    m_ptr = 0;
  endtask

  task automatic model(input logic [31:0] a, input logic lk, output logic ef,
                       output logic [PA-1:0] efa, output logic eh, output logic ee,
                       output logic [PA-1:0] epa);
    int w;
    int v;
    w = exp_win(a);
    ef = 0; efa = '0; eh = 0; ee = 0; epa = '0;
    if (w < 0) return;
    eh = 1;
    if (!w_sg[w]) begin
      epa = exp_direct(a, w);
      return;
    end
    for (int i = 0; i < 8; i++)
      if (m_v[i] && m_t[i] == a[31:13]) begin
        epa = {m_p[i], a[12:0]};
        return;
      end
    ef = 1;
    efa = exp_map(a, w);
    if (efa == bad_map) begin
      ee = 1;
      return;
    end
    epa = {mem_ppn(efa), a[12:0]};
    v = -1;
    for (int k = 0; k < 8; k++)
      if (v < 0 && !m_l[(m_ptr + k) % 8]) v = (m_ptr + k) % 8;
    if (v >= 0) begin
      m_v[v] = 1; m_l[v] = lk; m_t[v] = a[31:13]; m_p[v] = mem_ppn(efa);
      m_ptr = (v + 1) % 8;
    end
  endtask

  task automatic flush();
    @(negedge clk);
    inv_all = 1'b1;
    @(negedge clk);
    inv_all = 1'b0;
    for (int i = 0; i < 8; i++) if (!m_l[i]) m_v[i] = 0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_clear();
  endtask

  // one transaction plus comparison against the reference
  task automatic run(input logic [31:0] a, input logic lk, input string r);
    logic ef, eh, ee, gf;
    logic [PA-1:0] efa, epa, fa;
    model(a, lk, ef, efa, eh, ee, epa);
    @(negedge clk);
    chk({r, " ready"}, 64'(req_ready), 64'(1));
    req_valid = 1'b1; req_addr = a; req_lock = lk;
    @(negedge clk);
    req_valid = 1'b0; req_lock = 1'b0;
    gf = 0; fa = '0;
    if (!rsp_valid && fetch_valid) begin
      gf = 1; fa = fetch_addr;
      repeat ($urandom_range(0, 3)) @(negedge clk);
      chk("R4 hold", {rsp_valid, fetch_valid, req_ready, 27'd0, fetch_addr},
          {1'b0, 1'b1, 1'b0, 27'd0, fa});
      fill_valid = 1'b1;
      fill_data = (fa == bad_map) ? 22'd0 : {mem_ppn(fa), 1'b1};
      @(negedge clk);
      fill_valid = 1'b0;
    end
    chk({r, " fetch"}, {29'd0, gf, fa}, {29'd0, ef, efa});
    chk({r, " rsp"}, {27'd0, rsp_valid, rsp_hit, rsp_err, rsp_pa},
        {27'd0, 1'b1, eh, ee, epa});
  endtask

  initial begin
    for (int w = 0; w < NW; w++) begin
      cfg_en[w] = w_en[w];
      cfg_sg[w] = w_sg[w];
      cfg_base[w*12 +: 12] = w_base[w];
      cfg_mask[w*12 +: 12] = w_mask[w];
      cfg_tbase[w*PA +: PA] = w_tb[w];
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog actual hung expected done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    model_clear();
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 reset", {req_ready, rsp_valid, fetch_valid}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R12 after", {req_ready, rsp_valid, fetch_valid}, 3'b100);

    // R3 direct, R1 overlap priority, R2 disabled / unmapped
    run(32'h1012_3456, 0, "R3 direct");
    run(32'h10F0_0001, 0, "R3 direct top");
    run(32'h1045_6789, 0, "R1 overlap");
    run(32'h4000_0010, 0, "R2 disabled");
    run(32'h5000_0000, 0, "R2 unmapped");

    // R4 R5 miss then R7 hit
    run(32'h2012_2ABC, 0, "R5 miss");
    run(32'h2012_2001, 0, "R7 hit");
    run(32'h203F_FFFF, 0, "R4 last page");

    // R6 invalid entry
    bad_map = exp_map(32'h2030_0000, 1);
    run(32'h2030_0010, 0, "R6 bad");
    run(32'h2030_0020, 0, "R6 refetch");
    bad_map = '1;

    // R8 round robin over 9 pages
    flush();
    for (int k = 0; k < 9; k++) run(32'h2000_0000 + k * 32'h2000, 0, "R8 fill");
    run(32'h2000_0000, 0, "R8 evicted");
    run(32'h2000_4000, 0, "R8 kept");

    // R11 flush
    run(32'h2000_4000, 0, "R11 pre");
    flush();
    run(32'h2000_4000, 0, "R11 miss");

    // R9 locks survive flush, R10 uncached when all locked
    flush();
    for (int k = 0; k < 8; k++) run(32'h2010_0000 + k * 32'h2000, 1, "R9 lock");
    flush();
    for (int k = 0; k < 8; k++) run(32'h2010_0000 + k * 32'h2000, 0, "R9 held");
    run(32'h2020_0000, 0, "R10 uncached");
    run(32'h2020_0004, 0, "R10 again");

    do_reset();
    chk("R12 rereset", {req_ready, rsp_valid, fetch_valid}, 3'b100);

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a;
      int sel;
      sel = $urandom_range(0, 9);
      if (sel < 2)       a = {12'h100 | 12'($urandom_range(0, 15)), 20'($urandom)};
      else if (sel < 8)  a = {10'b0010_0000_00, 4'($urandom_range(0, 15)) , 5'd0, 13'($urandom)};
      else if (sel < 9)  a = {12'h400 | 12'($urandom_range(0, 1)), 20'($urandom)};
      else               a = $urandom;
      if ($urandom_range(0, 29) == 0) flush();
      run(a, ($urandom_range(0, 15) == 0), "R1 R3 R7 random");
    end

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule